// File: doc/BRIEF.md
# Rotating Frame Address Walker

This block turns a stored image into a stream of read addresses, one per pixel, ordered so that the image comes out turned by a quarter, half or three-quarter turn, or not turned at all. Each of these can also be mirrored. A pixel sits at base + (row · line pitch · vertical scale + column · horizontal scale) · bytes per pixel. The line pitch can be wider than the visible image, and either scale can repeat pixels.

A start pulse captures the configuration. From it the block works out the first address, the number of elements per output line, the number of output lines, and two signed strides. One stride is used inside a line. The other is used at each line change. The block then hands out addresses over a ready/valid handshake and marks the final one. A configuration that makes no sense raises an error flag instead of a walk. The block does not issue bus reads and does not carry pixel data.

Top module: `rot_addr_walker`

## Requirements
- R1: The size code `esize` selects the bytes per pixel: 0 gives 1, 1 gives 2, and 2 gives 4. Code 3 is rejected. On a rejected start, `cfg_err` is 1 from the second cycle after the start and `valid` stays 0.
- R2: Pixel (x, y) is read at base + (y·P·YS + x·XS)·E. P is `vwidth`, or `width` when `vwidth` is 0. XS and YS are the scale inputs, and a scale of 0 acts as 1. E is the byte count from R1.
- R3: These starts are rejected in the same way as in R1: a non-zero `vwidth` smaller than `width`, or a zero `width`, or a zero `height`. A later good start clears `cfg_err`.
- R4: `rotation` 0, 1, 2 and 3 mean 0, 90, 180 and 270 degrees. Codes 4 to 7 are rejected in the same way as in R1.
- R5: At 0 degrees, rows are visited top to bottom. Inside a row, x rises, or falls when `mirror` is 1.
- R6: At 90 degrees, columns are visited one after another. x rises, or falls when mirrored. Inside a column, y falls from height−1 to 0.
- R7: At 180 degrees, rows go bottom to top. Inside a row, x falls, or rises when mirrored. At 270 degrees, columns are visited with x falling, or rising when mirrored. Inside a column, y rises from 0.
- R8: A good start yields exactly width·height transfers. `last` is 1 on the final transfer and on no other.
- R9: While `valid` is 1 and `ready` is 0, the next cycle keeps `valid` at 1 and holds `addr` and `last` unchanged.
- R10: `busy` is 1 from the cycle after an accepted start until the final transfer. A start seen while `busy` is 1 has no effect on the address stream.
- R11: After reset, `valid`, `busy`, `last` and `cfg_err` are 0. `valid` first rises in the second cycle after the start and falls in the cycle after the final transfer. Addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the configuration and begin a walk (used only while idle) |
| base | input | 32 | Byte address of pixel (0,0) |
| width | input | 16 | Visible pixels per row |
| height | input | 16 | Visible rows |
| vwidth | input | 16 | Line pitch in pixels; 0 means equal to width |
| xscale | input | 8 | Horizontal scale; 0 means 1 |
| yscale | input | 8 | Vertical scale; 0 means 1 |
| esize | input | 2 | Bytes-per-pixel code |
| rotation | input | 3 | Turn code, 0 to 3 valid |
| mirror | input | 1 | Mirror the walk |
| ready | input | 1 | Consumer accepts the current address |
| valid | output | 1 | An address is offered |
| addr | output | 32 | Byte address of the current pixel |
| last | output | 1 | Current address is the final one of the frame |
| busy | output | 1 | A walk is pending or running |
| cfg_err | output | 1 | The last start was rejected |

## Verification
The walk is kept as an address register and two counters, and it moves only by adding strides. A wrong stride or a wrong first address therefore shows up on `addr` at the first transfer, or at the first line change, and every later address is wrong as well. A wrong element or line counter shows up as a misplaced line change, as `last` at the wrong transfer, or as a transfer count other than width·height. Each of these is visible at the latest when the frame ends. The bench builds every expected address from pixel coordinates and compares each transfer as it happens, so the first wrong cycle is the one reported.

// File: rtl/rw_pkg.sv
package rw_pkg;
    localparam int AW  = 32;   // address width
    localparam int DW  = 16;   // dimension / counter width
    localparam int SW  = 8;    // scale width
    localparam int EIW = 16;   // element stride width (signed)
    localparam int FIW = 32;   // line stride width (signed)
    localparam int EBW = 3;    // bytes-per-pixel width

    typedef enum logic [1:0] {
        PX_1B  = 2'd0,
        PX_2B  = 2'd1,
        PX_4B  = 2'd2,
        PX_BAD = 2'd3
    } px_code_e;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [DW-1:0] wid;
        logic [DW-1:0] hgt;
        logic [DW-1:0] pitch;
        logic [SW-1:0] xs;
        logic [SW-1:0] ys;
        logic [1:0]    pxc;
        logic [2:0]    turn;
        logic          flip;
    } cfg_t;

    typedef struct packed {
        logic [AW-1:0]         first;
        logic signed [EIW-1:0] estep;
        logic signed [FIW-1:0] lstep;
        logic [DW-1:0]         per_line;
        logic [DW-1:0]         lines;
        logic [EBW-1:0]        nbytes;
        logic                  bad;
    } plan_t;

    typedef struct packed {
        cfg_t cfg;
        logic load;
    } front_t;

    typedef struct packed {
        logic          run;
        logic          err;
        logic [AW-1:0] addr;
        logic [DW-1:0] ecnt;
        logic [DW-1:0] lcnt;
    } walk_t;
endpackage

// File: rtl/rw_setup.sv
module rw_setup
    import rw_pkg::*;
(
    input  cfg_t  cfg,
    output plan_t plan
);
    function automatic logic [AW-1:0] offset_of(
        input logic [DW-1:0]  x,
        input logic [DW-1:0]  y,
        input logic [AW-1:0]  row_bytes_px,
        input logic [SW-1:0]  xs,
        input logic [EBW-1:0] nb
    );
        offset_of = (AW'(y) * row_bytes_px + AW'(x) * AW'(xs)) * AW'(nb);
    endfunction

    logic [EBW-1:0] nb;
    logic [DW-1:0]  pitch_eff;
    logic [SW-1:0]  xs_eff, ys_eff;
    logic [AW-1:0]  row_px;
    logic [DW-1:0]  xl, yl;
    logic [DW-1:0]  tx, ty, e0x, e0y, e1x, e1y, f0x, f0y, f1x, f1y;
    logic [AW-1:0]  ediff, fdiff;
    logic           err;

    always_comb begin
        case (px_code_e'(cfg.pxc))
            PX_1B:   nb = EBW'(1);
            PX_2B:   nb = EBW'(2);
            PX_4B:   nb = EBW'(4);
            default: nb = EBW'(1);
        endcase
        pitch_eff = (cfg.pitch == '0) ? cfg.wid : cfg.pitch;
        xs_eff    = (cfg.xs == '0) ? SW'(1) : cfg.xs;
        ys_eff    = (cfg.ys == '0) ? SW'(1) : cfg.ys;
        row_px    = AW'(pitch_eff) * AW'(ys_eff);
        xl        = cfg.wid - DW'(1);
        yl        = cfg.hgt - DW'(1);

        // first pixel (t), element step e0->e1, line step f0->f1
        tx = '0; ty = '0;
        e0x = '0; e0y = '0; e1x = '0; e1y = '0;
        f0x = '0; f0y = '0; f1x = '0; f1y = '0;
        case ({cfg.turn[1:0], cfg.flip})
            3'b000: begin tx = '0; ty = '0;  e1x = DW'(1);
                          f0x = xl; f1y = DW'(1); end
            3'b001: begin tx = xl; ty = '0;  e0x = DW'(1);
                          f1x = xl; f1y = DW'(1); end
            3'b010: begin tx = '0; ty = yl;  e0y = DW'(1);
                          f1x = DW'(1); f1y = yl; end
            3'b011: begin tx = xl; ty = yl;  e0y = DW'(1);
                          f0x = DW'(1); f1y = yl; end
            3'b100: begin tx = xl; ty = yl;  e0x = DW'(1);
                          f0y = DW'(1); f1x = xl; end
            3'b101: begin tx = '0; ty = yl;  e1x = DW'(1);
                          f0x = xl; f0y = DW'(1); end
            3'b110: begin tx = xl; ty = '0;  e1y = DW'(1);
                          f0x = DW'(1); f0y = yl; end
            default: begin tx = '0; ty = '0; e1y = DW'(1);
                          f0y = yl; f1x = DW'(1); end
        endcase

        ediff = offset_of(e1x, e1y, row_px, xs_eff, nb)
              - offset_of(e0x, e0y, row_px, xs_eff, nb)
              - AW'(nb) + AW'(1);
        fdiff = offset_of(f1x, f1y, row_px, xs_eff, nb)
              - offset_of(f0x, f0y, row_px, xs_eff, nb)
              - AW'(nb) + AW'(1);

        err = (cfg.pxc == PX_BAD) || cfg.turn[2] ||
              (cfg.wid == '0) || (cfg.hgt == '0) ||
              ((cfg.pitch != '0) && (cfg.pitch < cfg.wid));

        plan.first    = cfg.base + offset_of(tx, ty, row_px, xs_eff, nb);
        plan.estep    = $signed(ediff[EIW-1:0]);
        plan.lstep    = $signed(fdiff[FIW-1:0]);
        plan.per_line = cfg.turn[0] ? cfg.hgt : cfg.wid;
        plan.lines    = cfg.turn[0] ? cfg.wid : cfg.hgt;
        plan.nbytes   = nb;
        plan.bad      = err;
    end
endmodule

// File: rtl/rw_walk.sv
module rw_walk
    import rw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  plan_t         plan,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          running,
    output logic          err
);
    walk_t q, d;
    logic  end_line, end_frame;
    logic [AW-1:0] estep_ext, lstep_ext, post_inc;

    always_comb begin
        end_line  = (q.ecnt == plan.per_line - DW'(1));
        end_frame = end_line && (q.lcnt == plan.lines - DW'(1));
        estep_ext = {{(AW-EIW){plan.estep[EIW-1]}}, plan.estep};
        lstep_ext = AW'($unsigned(plan.lstep));
        post_inc  = AW'(plan.nbytes) - AW'(1);

        d = q;
        if (!q.run) begin
            if (load) begin
                if (plan.bad) begin
                    d.err = 1'b1;
                end else begin
                    d.err  = 1'b0;
                    d.run  = 1'b1;
                    d.addr = plan.first;
                    d.ecnt = '0;
                    d.lcnt = '0;
                end
            end
        end else if (ready) begin
            if (end_frame) begin
                d.run = 1'b0;
            end else if (end_line) begin
                d.ecnt = '0;
                d.lcnt = q.lcnt + DW'(1);
                d.addr = q.addr + lstep_ext + post_inc;
            end else begin
                d.ecnt = q.ecnt + DW'(1);
                d.addr = q.addr + estep_ext + post_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid   = q.run;
    assign addr    = q.addr;
    assign last    = q.run && end_frame;
    assign running = q.run;
    assign err     = q.err;
endmodule

// File: rtl/rot_addr_walker.sv
module rot_addr_walker
    import rw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [DW-1:0] vwidth,
    input  logic [SW-1:0] xscale,
    input  logic [SW-1:0] yscale,
    input  logic [1:0]    esize,
    input  logic [2:0]    rotation,
    input  logic          mirror,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          busy,
    output logic          cfg_err
);
    front_t q, d;
    plan_t  plan;
    logic   running;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        if (start && !busy) begin
            d.load       = 1'b1;
            d.cfg.base   = base;
            d.cfg.wid    = width;
            d.cfg.hgt    = height;
            d.cfg.pitch  = vwidth;
            d.cfg.xs     = xscale;
            d.cfg.ys     = yscale;
            d.cfg.pxc    = esize;
            d.cfg.turn   = rotation;
            d.cfg.flip   = mirror;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rw_setup u_setup (
        .cfg  (q.cfg),
        .plan (plan)
    );

    rw_walk u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (q.load),
        .plan    (plan),
        .ready   (ready),
        .valid   (valid),
        .addr    (addr),
        .last    (last),
        .running (running),
        .err     (cfg_err)
    );

    assign busy = q.load | running;
endmodule

// File: rtl/rot_addr_walker_chk.sv
module rot_addr_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input logic        valid,
    input logic [31:0] addr,
    input logic        last,
    input logic        busy,
    input logic        cfg_err
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(last)));

    assert_last_in_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !valid);

    assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);

    assert_drop_after_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && last) |=> !valid);
endmodule

bind rot_addr_walker rot_addr_walker_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready),
    .valid   (valid),
    .addr    (addr),
    .last    (last),
    .busy    (busy),
    .cfg_err (cfg_err)
);

// File: tb/sim_rot_addr_walker.sv
module sim_rot_addr_walker;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start, mirror, ready;
    logic [31:0] base;
    logic [15:0] width, height, vwidth;
    logic [7:0]  xscale, yscale;
    logic [1:0]  esize;
    logic [2:0]  rotation;
    logic        valid, last, busy, cfg_err;
    logic [31:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q[$];

    rot_addr_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base),
        .width(width), .height(height), .vwidth(vwidth),
        .xscale(xscale), .yscale(yscale), .esize(esize),
        .rotation(rotation), .mirror(mirror), .ready(ready),
        .valid(valid), .addr(addr), .last(last), .busy(busy),
        .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pix(input logic [31:0] b, input int x, input int y,
                                        input int p, input int xs, input int ys, input int e);
        logic [31:0] o;
        o = (32'(y) * 32'(p) * 32'(ys) + 32'(x) * 32'(xs)) * 32'(e);
        return b + o;
    endfunction

    task automatic build(input logic [31:0] b, input int w, input int h, input int vw,
                         input int xs, input int ys, input int ez, input int rt, input bit mi);
        int p, sx, sy, e, x, y;
        p  = (vw == 0) ? w : vw;
        sx = (xs == 0) ? 1 : xs;
        sy = (ys == 0) ? 1 : ys;
        e  = (ez == 0) ? 1 : (ez == 1) ? 2 : 4;
        exp_q.delete();
        if (rt == 0 || rt == 2) begin
            for (int i = 0; i < h; i++) begin
                y = (rt == 0) ? i : h - 1 - i;
                for (int j = 0; j < w; j++) begin
                    if (rt == 0) x = mi ? w - 1 - j : j;
                    else         x = mi ? j : w - 1 - j;
                    exp_q.push_back(pix(b, x, y, p, sx, sy, e));
                end
            end
        end else begin
            for (int j = 0; j < w; j++) begin
                if (rt == 1) x = mi ? w - 1 - j : j;
                else         x = mi ? j : w - 1 - j;
                for (int i = 0; i < h; i++) begin
                    y = (rt == 1) ? h - 1 - i : i;
                    exp_q.push_back(pix(b, x, y, p, sx, sy, e));
                end
            end
        end
    endtask

    task automatic drive(input logic [31:0] b, input int w, input int h, input int vw,
                         input int xs, input int ys, input int ez, input int rt, input bit mi);
        base = b; width = 16'(w); height = 16'(h); vwidth = 16'(vw);
        xscale = 8'(xs); yscale = 8'(ys); esize = 2'(ez);
        rotation = 3'(rt); mirror = mi;
    endtask

    task automatic run_frame(input logic [31:0] b, input int w, input int h, input int vw,
                             input int xs, input int ys, input int ez, input int rt,
                             input bit mi, input bit stall, input bit poke, input string tag);
        int guard, k;
        bit hold_pend;
        logic [31:0] hold_a, e;
        logic hold_l;
        build(b, w, h, vw, xs, ys, ez, rt, mi);
        @(negedge clk);
        drive(b, w, h, vw, xs, ys, ez, rt, mi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", 32'(busy), 1);
        chk(valid == 1'b0, "R11", "valid one cycle after start", 32'(valid), 0);
        @(negedge clk);
        chk(valid == 1'b1, "R11", "valid two cycles after start", 32'(valid), 1);
        chk(cfg_err == 1'b0, "R3", "error flag after good start", 32'(cfg_err), 0);
        guard = 0; k = 0; hold_pend = 1'b0; hold_a = '0; hold_l = 1'b0;
        while (exp_q.size() > 0 && guard < 20000) begin
            if (hold_pend)
                chk(valid && addr == hold_a && last == hold_l, "R9",
                    "held address", addr, hold_a);
            hold_pend = 1'b0;
            k++;
            ready = stall ? (k % 3 != 0) : 1'b1;
            if (poke && k == 3) begin
                drive(32'h0, 2, 2, 0, 0, 0, 0, 0, 1'b0);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            chk(valid == 1'b1, "R8", "valid during walk", 32'(valid), 1);
            if (valid && ready) begin
                e = exp_q.pop_front();
                chk(addr == e, tag, "address", addr, e);
                chk(last == (exp_q.size() == 0), "R8", "last flag",
                    32'(last), 32'(exp_q.size() == 0));
            end else if (valid) begin
                hold_pend = 1'b1;
                hold_a = addr;
                hold_l = last;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        ready = 1'b1;
        chk(valid == 1'b0, "R11", "valid after final transfer", 32'(valid), 0);
        chk(busy == 1'b0, "R10", "busy after final transfer", 32'(busy), 0);
    endtask

    task automatic run_err(input logic [31:0] b, input int w, input int h, input int vw,
                           input int ez, input int rt, input string tag);
        @(negedge clk);
        drive(b, w, h, vw, 0, 0, ez, rt, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(cfg_err == 1'b1, tag, "rejected start flag", 32'(cfg_err), 1);
        chk(valid == 1'b0, tag, "no walk on rejected start", 32'(valid), 0);
        chk(busy == 1'b0, "R10", "idle after rejected start", 32'(busy), 0);
        repeat (3) begin
            @(negedge clk);
            chk(valid == 1'b0, tag, "still no walk", 32'(valid), 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; ready = 1'b1;
        drive(32'h0, 1, 1, 0, 0, 0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0, "R11", "reset valid", 32'(valid), 0);
        chk(busy == 1'b0, "R11", "reset busy", 32'(busy), 0);
        chk(last == 1'b0, "R11", "reset last", 32'(last), 0);
        chk(cfg_err == 1'b0, "R11", "reset error flag", 32'(cfg_err), 0);

        run_frame(32'h0000_1000, 4, 3, 0, 0, 0, 1, 0, 1'b0, 1'b0, 1'b0, "R5");
        run_frame(32'h0000_2000, 5, 3, 0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b0, "R5");
        run_frame(32'h0000_3000, 4, 3, 8, 0, 0, 2, 1, 1'b0, 1'b1, 1'b0, "R6");
        run_frame(32'h0000_4000, 3, 4, 0, 2, 3, 1, 1, 1'b1, 1'b0, 1'b0, "R6");
        run_frame(32'h0000_5000, 4, 3, 0, 0, 0, 0, 2, 1'b0, 1'b0, 1'b0, "R7");
        run_frame(32'h0000_6000, 4, 3, 6, 0, 0, 1, 2, 1'b1, 1'b1, 1'b0, "R7");
        run_frame(32'h0000_7000, 4, 3, 6, 0, 0, 2, 3, 1'b0, 1'b1, 1'b0, "R7");
        run_frame(32'h0000_8000, 3, 5, 0, 3, 2, 0, 3, 1'b1, 1'b0, 1'b0, "R7");
        run_frame(32'h0001_0000, 6, 4, 10, 2, 2, 1, 0, 1'b0, 1'b1, 1'b0, "R2");
        run_frame(32'hFFFF_FFF0, 4, 2, 0, 0, 0, 2, 0, 1'b0, 1'b0, 1'b0, "R11");
        run_frame(32'h0000_9000, 1, 1, 0, 0, 0, 2, 2, 1'b1, 1'b0, 1'b0, "R8");
        run_frame(32'h0000_A000, 4, 4, 0, 0, 0, 1, 1, 1'b0, 1'b1, 1'b1, "R10");

        run_err(32'h0000_B000, 4, 3, 0, 3, 0, "R1");
        run_frame(32'h0000_C000, 2, 2, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R1");
        run_err(32'h0000_B000, 4, 3, 0, 1, 5, "R4");
        run_err(32'h0000_B000, 4, 3, 3, 1, 0, "R3");
        run_err(32'h0000_B000, 0, 3, 0, 1, 0, "R3");
        run_frame(32'h0000_D000, 2, 3, 4, 0, 0, 1, 0, 1'b0, 1'b0, 1'b0, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule